// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block estimates the frequency of one of several monitored clocks by timing it against a fixed reference clock. Software chooses a monitored channel and a window length in monitored-clock cycles, turns on the free-running reference gate, and then raises the meter enable. The monitored clock domain counts out the window. Meanwhile the reference domain counts its own cycles from the start of the run until the completion event arrives. The frozen reference count is then shown on the value output and the valid flag goes high.

The two clock domains exchange exactly two single-bit events, each through a two-stage synchronizer: the enable crosses from the reference side into the monitored side, and the window-done event crosses back. The channel and the window length are captured when the enable rises, so they stay fixed for the whole run. If the monitored clock is missing, the run never completes. In that case the value output stays at zero, and zero is the failure indication. To use the result, divide the window length times the reference frequency by the count.

Top module: `freq_meter`

## Requirements
- R1: While reset is high and for the first cycles after reset, `meas_valid` is 0 and `meas_value` is 0. Whenever `meas_valid` is 0, `meas_value` is 0.
- R2: With a monitored period of P reference cycles and a window of N cycles, the completed count lies between N·P and (N+4)·P+6. The extra margin covers synchronizer latency.
- R3: After `meas_valid` rises it stays high and `meas_value` stays unchanged for as long as `meter_en` remains high.
- R4: After `meter_en` is sampled low at a reference edge, `meas_valid` and `meas_value` are both 0 from the second following edge onward. If this clear and the window completion fall in the same cycle, the clear wins.
- R5: When `meter_en` is lowered and raised again, a fresh run starts, and it uses the settings present at the new rising edge.
- R6: `chan_sel` picks the monitored input by index. Value k measures `mon_clk[k]`.
- R7: If `chan_sel` or `win_len` changes while `meter_en` is high, the current run is unaffected. The new values take effect only at the next rise of `meter_en`.
- R8: While `frun_en` is 0 the reference counter does not advance. A run that completes under this condition reports `meas_valid`=1 with `meas_value`=0, which marks a failed detection.
- R9: If the selected monitored clock is stopped, `meas_valid` never rises and `meas_value` stays 0.
- R10: The reference count saturates at 2^REF_W−1 and does not wrap.
- R11: A `win_len` of 0 is treated as a window of one monitored cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control and result logic runs on it |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| mon_clk | input | NCH | Monitored clock inputs |
| meter_en | input | 1 | Starts a run on its rise; clears the result while low |
| frun_en | input | 1 | Gate for the free-running reference count |
| win_len | input | CNT_W | Window length in monitored-clock cycles |
| chan_sel | input | SEL_W | Index of the monitored clock to measure |
| meas_value | output | REF_W | Reference cycles counted during the run; 0 when not valid |
| meas_valid | output | 1 | High once the run has completed |

## Verification
The completion of a window and the deassertion of the enable can land in the same reference cycle. That is the point where a set of the valid flag and a clear of the result compete. The bench first measures how many cycles a fixed run takes. It then repeats that run and drops the enable at several offsets around that cycle count. For every offset it requires valid and value to read zero two edges after the drop, and to stay at zero while the enable remains low. A per-clock model built from the sampled enable history checks the clear, the hold and the zero-when-invalid rules on every cycle.

// File: rtl/fm_pkg.sv
package fm_pkg;
  // Smallest legal select width for a channel count
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain = '0;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fm_window.sv
module fm_window #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  logic [CNT_W-1:0] cnt = '0;
  logic             done_r = 1'b0;
  logic [CNT_W:0]   len_eff;
  logic [CNT_W:0]   cnt_nx;

  // zero length behaves as a single-cycle window
  assign len_eff = (len == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, len};
  assign cnt_nx  = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!run) begin
      cnt    <= '0;
      done_r <= 1'b0;
    end else if (!done_r) begin
      cnt <= cnt_nx[CNT_W-1:0];
      if (cnt_nx >= len_eff) done_r <= 1'b1;
    end
  end

  assign done = done_r;
endmodule

// File: rtl/fm_refcnt.sv
module fm_refcnt #(
  parameter int REF_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             frun,
  input  logic             done_s,
  output logic [REF_W-1:0] value,
  output logic             valid
);
  localparam logic [REF_W-1:0] CNT_MAX = '1;

  logic [REF_W-1:0] cnt;
  logic [REF_W-1:0] val_r;
  logic             armed;
  logic             valid_r;
  logic             fire;

  // a done level is only trusted after it has been seen low in this run
  assign fire = armed && done_s && !valid_r;

  always_ff @(posedge clk) begin
    if (rst || !en_q) begin
      cnt     <= '0;
      val_r   <= '0;
      armed   <= 1'b0;
      valid_r <= 1'b0;
    end else begin
      if (!done_s) armed <= 1'b1;
      if (frun && !valid_r && cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (fire) begin
        valid_r <= 1'b1;
        val_r   <= cnt;
      end
    end
  end

  assign value = val_r;
  assign valid = valid_r;

  // R10
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R9
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_r) |-> $past(done_s));

  // R1
  zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_r |-> (val_r == '0));
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int NCH   = 4,
  parameter int CNT_W = 24,
  parameter int REF_W = 24,
  parameter int SEL_W = fm_pkg::sel_width(NCH)
) (
  input  logic             ref_clk,
  input  logic             ref_rst,
  input  logic [NCH-1:0]   mon_clk,
  input  logic             meter_en,
  input  logic             frun_en,
  input  logic [CNT_W-1:0] win_len,
  input  logic [SEL_W-1:0] chan_sel,
  output logic [REF_W-1:0] meas_value,
  output logic             meas_valid
);
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] len_q;
  logic             mclk;
  logic             run_m;
  logic             done_m;
  logic             done_s;

  // settings are captured on the rise of the enable
  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      en_q  <= 1'b0;
      sel_q <= '0;
      len_q <= '0;
    end else begin
      en_q <= meter_en;
      if (meter_en && !en_q) begin
        sel_q <= chan_sel;
        len_q <= win_len;
      end
    end
  end

  assign mclk = mon_clk[sel_q];

  fm_sync u_en_sync (.clk(mclk), .d(en_q), .q(run_m));

  fm_window #(.CNT_W(CNT_W)) u_win (
    .clk(mclk), .run(run_m), .len(len_q), .done(done_m)
  );

  fm_sync u_done_sync (.clk(ref_clk), .d(done_m), .q(done_s));

  fm_refcnt #(.REF_W(REF_W)) u_ref (
    .clk(ref_clk), .rst(ref_rst), .en_q(en_q), .frun(frun_en),
    .done_s(done_s), .value(meas_value), .valid(meas_valid)
  );

  // R4
  clear_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    !meter_en |=> ##1 (!meas_valid && meas_value == '0));

  // R3
  hold_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (meas_valid && en_q && meter_en) |=> (meas_valid && $stable(meas_value)));

  // R7
  sel_keep_chk: assert property (@(posedge ref_clk) disable iff (ref_rst)
    (en_q && meter_en) |=> ($stable(sel_q) && $stable(len_q)));
endmodule

// File: tb/freq_meter_test.sv
module freq_meter_test;
  logic        ref_clk = 1'b0;
  logic        ref_rst = 1'b1;
  logic [3:0]  mon_clk = 4'b0;
  logic        mon3_on = 1'b1;
  logic        meter_en = 1'b0;
  logic        frun_en = 1'b1;
  logic [23:0] win_len = 24'd0;
  logic [1:0]  chan_sel = 2'd0;
  logic [23:0] meas_value;
  logic        meas_valid;
  logic [5:0]  sat_value;
  logic        sat_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit model_on = 1'b0;
  bit en_hist[$];
  bit prev_valid = 1'b0;
  int prev_value = 0;

  always #10 ref_clk = ~ref_clk;
  always #30 mon_clk[0] = ~mon_clk[0];
  always #50 mon_clk[1] = ~mon_clk[1];
  always #70 mon_clk[2] = ~mon_clk[2];
  always #110 if (mon3_on) mon_clk[3] = ~mon_clk[3];

  freq_meter uut (
    .ref_clk(ref_clk), .ref_rst(ref_rst), .mon_clk(mon_clk),
    .meter_en(meter_en), .frun_en(frun_en), .win_len(win_len),
    .chan_sel(chan_sel), .meas_value(meas_value), .meas_valid(meas_valid)
  );

  freq_meter #(.REF_W(6)) u_small (
    .ref_clk(ref_clk), .ref_rst(ref_rst), .mon_clk(mon_clk),
    .meter_en(meter_en), .frun_en(frun_en), .win_len(win_len),
    .chan_sel(chan_sel), .meas_value(sat_value), .meas_valid(sat_valid)
  );

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  // enable history sampled at each reference edge
  always @(posedge ref_clk) begin
    cyc++;
    en_hist.push_front(meter_en);
    if (en_hist.size() > 3) void'(en_hist.pop_back());
  end

  // per-clock model of the clear, hold and zero rules
  always @(negedge ref_clk) begin
    if (model_on && en_hist.size() >= 2) begin
      if (en_hist[1] == 1'b0) begin
        chk_eq("R4 valid after clear", int'(meas_valid), 0);
        chk_eq("R4 value after clear", int'(meas_value), 0);
      end else if (prev_valid) begin
        chk_eq("R3 valid held", int'(meas_valid), 1);
        chk_eq("R3 value held", int'(meas_value), prev_value);
      end
      if (!meas_valid) chk_eq("R1 value zero when invalid", int'(meas_value), 0);
    end
    prev_valid = meas_valid;
    prev_value = int'(meas_value);
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic start(input int ch, input int len, input bit fr);
    @(negedge ref_clk);
    meter_en = 1'b0;
    idle(60);
    chan_sel = ch[1:0];
    win_len = len[23:0];
    frun_en = fr;
    meter_en = 1'b1;
  endtask

  task automatic wait_valid(input int limit, output int lat, output bit got);
    got = 1'b0;
    lat = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge ref_clk);
      lat++;
      if (meas_valid) begin
        got = 1'b1;
        break;
      end
    end
  endtask

  task automatic measure(input int ch, input int len, input bit fr, output int val, output int lat);
    bit got;
    start(ch, len, fr);
    wait_valid(6000, lat, got);
    chk_eq("R3 valid rises", int'(got), 1);
    val = int'(meas_value);
  endtask

  initial begin
    int v, lat, base_lat;
    int per[4] = '{3, 5, 7, 11};
    bit got;
    idle(5);
    chk_eq("R1 reset valid", int'(meas_valid), 0);
    chk_eq("R1 reset value", int'(meas_value), 0);
    @(negedge ref_clk);
    ref_rst = 1'b0;
    model_on = 1'b1;
    idle(3);
    chk_eq("R1 post reset valid", int'(meas_valid), 0);

    // R6 R5: every channel, re-enabled each time
    for (int ch = 0; ch < 4; ch++) begin
      measure(ch, 16, 1'b1, v, lat);
      chk_rng($sformatf("R6 R2 channel %0d", ch), v, 16 * per[ch], 20 * per[ch] + 6);
    end

    // R2 other window lengths
    measure(0, 40, 1'b1, v, lat);
    chk_rng("R2 window 40 ch0", v, 120, 138);
    measure(2, 5, 1'b1, v, lat);
    chk_rng("R2 window 5 ch2", v, 35, 69);

    // R11 zero length window
    measure(1, 0, 1'b1, v, lat);
    chk_rng("R11 zero window", v, 5, 31);

    // R3 hold for a while after completion
    idle(30);
    chk_eq("R3 valid still high", int'(meas_valid), 1);

    // R7 settings change mid-run
    start(1, 20, 1'b1);
    idle(10);
    chan_sel = 2'd3;
    win_len = 24'd2;
    wait_valid(6000, lat, got);
    chk_eq("R7 run completes", int'(got), 1);
    chk_rng("R7 original settings kept", int'(meas_value), 100, 126);

    // R8 free-run gate off
    measure(0, 4, 1'b0, v, lat);
    chk_eq("R8 failed detection value", v, 0);
    frun_en = 1'b1;

    // R10 saturation in the narrow instance
    measure(3, 30, 1'b1, v, lat);
    chk_rng("R10 wide count", v, 330, 380);
    idle(2);
    chk_eq("R10 narrow valid", int'(sat_valid), 1);
    chk_eq("R10 narrow saturated", int'(sat_value), 63);

    // R4 clear racing completion
    measure(0, 8, 1'b1, v, base_lat);
    for (int off = -3; off <= 3; off++) begin
      start(0, 8, 1'b1);
      idle(base_lat + off - 1);
      meter_en = 1'b0;
      idle(2);
      chk_eq($sformatf("R4 race valid off %0d", off), int'(meas_valid), 0);
      chk_eq($sformatf("R4 race value off %0d", off), int'(meas_value), 0);
      idle(6);
      chk_eq($sformatf("R4 race stays clear off %0d", off), int'(meas_valid), 0);
    end

    // R9 stopped monitored clock
    mon3_on = 1'b0;
    start(3, 4, 1'b1);
    idle(600);
    chk_eq("R9 no valid without clock", int'(meas_valid), 0);
    chk_eq("R9 value zero without clock", int'(meas_value), 0);

    meter_en = 1'b0;
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected below 150000 cycles", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule